// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

The block collects up to eight interrupt request lines and forwards the most urgent one to a processor as a single interrupt output. Software programs it through a byte-wide command port and data port, selected by one address bit. A command write with bit 4 set starts a fixed initialization sequence on the data port. The first word gives the vector base. A cascade word follows unless single mode was chosen. A mode word follows only if the start word asked for one. Once the sequence is done, the data port reads and writes the interrupt mask.

Requests are latched on rising edges, or followed directly as levels. The lowest-numbered unmasked request wins. It raises the interrupt output only when it outranks everything already in service. A one-cycle acknowledge hands back the vector and marks the line in service. A non-specific end-of-interrupt command releases the most urgent in-service line. Automatic end-of-interrupt and special fully nested operation are selectable in the mode word. The cascade word is stored and driven out for the surrounding system.

The bus has no back-pressure. Every write is taken in the cycle it is presented. Read data and the acknowledge vector are valid combinationally in the cycle of the request.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, and until an initialization sequence completes, the interrupt output stays low. In that period data-port writes are ignored, and a data-port read returns 0xFF.
- R2: A command write with bit 4 set starts initialization. Bit 0 of that word requests a mode word, bit 1 selects single mode (1) or cascade mode (0), and bit 3 selects level mode (1) or edge mode (0). The next data write is the vector base. In cascade mode the data write after it is the cascade word, which appears on `cfg_cascade` after the write.
- R3: In single mode the cascade word is skipped, so the data write after the vector base is taken as the mode word or as a mask write.
- R4: Completing initialization sets the mask to 0x00. A data-port read returns the mask in the same cycle.
- R5: After initialization a data-port write loads the mask, where bit n = 1 masks line n. A masked line never raises the interrupt output, but its latched edge request is kept until the line is unmasked.
- R6: Line 0 has the highest priority. The vector returned during acknowledge is the vector base plus the index of the winning line.
- R7: An acknowledge moves the winning line into service. Afterwards, a request of equal or lower priority does not raise the interrupt output, and a request of higher priority does.
- R8: A command write of 0x20 clears the lowest-numbered set in-service bit. Other command writes with bit 4 clear have no effect.
- R9: With mode-word bit 1 set (automatic end-of-interrupt), an acknowledge sets no in-service bit, so a lower-priority request raises the output right away.
- R10: In edge mode a request is latched on the cycle after a rising input. It stays latched after the input falls and is cleared by its acknowledge. An input held high does not latch again.
- R11: In level mode the request follows the input in the same cycle, with no latching.
- R12: With mode-word bit 4 set (special fully nested), a request of the same line as the highest in-service line raises the output.
- R13: A start word written at any point restarts the sequence. If its bit 0 is clear, no mode word is expected.
- R14: An acknowledge while the interrupt output is low returns the vector base plus 7 and changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 1 | Port select: 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: the vector during acknowledge, the mask on a data read, otherwise 0 |
| req_in | input | 8 | Interrupt request lines, line 0 most urgent |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | One-cycle interrupt acknowledge |
| cfg_cascade | output | 8 | Stored cascade word |

## Verification
Register writes act at the clock edge that samples the strobe. Their effect on `int_out` and on read data is checked in the following low clock phase.

Read data and the acknowledge vector are combinational, so they are sampled 1 ns after the strobe is driven on the falling edge. In level mode `int_out` is also combinational and is sampled in that same phase. In edge mode `int_out` is sampled one falling edge later than the request change, because the edge first passes through one register.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_VEC,
    ST_CAS,
    ST_MODE,
    ST_RUN
  } init_st_e;

  localparam int          START_BIT  = 4;
  localparam int          FLG_MODEW  = 0;
  localparam int          FLG_SINGLE = 1;
  localparam int          FLG_LEVEL  = 3;
  localparam int          MODE_AUTO  = 1;
  localparam int          MODE_NEST  = 4;
  localparam logic [7:0]  EOI_WORD   = 8'h20;
endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_cmd,
  input  logic                 wr_dat,
  input  logic [DATA_W-1:0]    wdata,
  output logic                 restart,
  output logic                 eoi_cmd,
  output logic                 ready,
  output logic [DATA_W-1:0]    vbase,
  output logic [DATA_W-1:0]    cascade,
  output logic                 level_mode,
  output logic                 auto_eoi,
  output logic                 nested,
  output logic [NUM_LINES-1:0] mask
);
  init_st_e st_q, st_d;
  logic     want_mode_q, single_q;

  assign restart = wr_cmd && wdata[START_BIT];
  assign eoi_cmd = wr_cmd && !wdata[START_BIT] && (wdata == EOI_WORD);
  assign ready   = (st_q == ST_RUN);

  // next state for a data write inside the sequence
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_VEC:  st_d = !single_q ? ST_CAS : (want_mode_q ? ST_MODE : ST_RUN);
      ST_CAS:  st_d = want_mode_q ? ST_MODE : ST_RUN;
      ST_MODE: st_d = ST_RUN;
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_UNINIT;
      want_mode_q <= 1'b0;
      single_q    <= 1'b0;
      level_mode  <= 1'b0;
      auto_eoi    <= 1'b0;
      nested      <= 1'b0;
      vbase       <= '0;
      cascade     <= '0;
      mask        <= '1;
    end else if (restart) begin
      st_q        <= ST_VEC;
      want_mode_q <= wdata[FLG_MODEW];
      single_q    <= wdata[FLG_SINGLE];
      level_mode  <= wdata[FLG_LEVEL];
      auto_eoi    <= 1'b0;
      nested      <= 1'b0;
    end else if (wr_dat) begin
      unique case (st_q)
        ST_VEC:  vbase   <= wdata;
        ST_CAS:  cascade <= wdata;
        ST_MODE: begin
          auto_eoi <= wdata[MODE_AUTO];
          nested   <= wdata[MODE_NEST];
        end
        ST_RUN:  mask <= wdata[NUM_LINES-1:0];
        default: ;
      endcase
      if (st_q != ST_RUN && st_q != ST_UNINIT && st_d == ST_RUN)
        mask <= '0;
      st_q <= st_d;
    end
  end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_all,
  input  logic                 level_mode,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic [NUM_LINES-1:0] ack_clr,
  output logic [NUM_LINES-1:0] irr
);
  logic [NUM_LINES-1:0] prev_q, edge_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= req_in;
      if (clear_all) edge_q <= '0;
      else           edge_q <= (edge_q & ~ack_clr) | (req_in & ~prev_q);
    end
  end

  assign irr = level_mode ? req_in : edge_q;
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 ready,
  input  logic                 nested,
  input  logic [NUM_LINES-1:0] irr,
  input  logic [NUM_LINES-1:0] mask,
  input  logic [NUM_LINES-1:0] isr,
  output logic                 int_req,
  output logic [IDX_W-1:0]     win_idx,
  output logic [NUM_LINES-1:0] win_hot
);
  logic [NUM_LINES-1:0] cand;
  logic [IDX_W-1:0]     svc_idx;
  logic                 cand_any, svc_any;

  assign cand = irr & ~mask;

  always_comb begin
    win_idx  = IDX_W'(NUM_LINES - 1);
    svc_idx  = IDX_W'(NUM_LINES - 1);
    cand_any = 1'b0;
    svc_any  = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_idx  = IDX_W'(i);
        cand_any = 1'b1;
      end
      if (isr[i]) begin
        svc_idx = IDX_W'(i);
        svc_any = 1'b1;
      end
    end
  end

  always_comb begin
    win_hot = '0;
    win_hot[win_idx] = cand_any;
  end

  assign int_req = ready && cand_any &&
                   (!svc_any || (win_idx < svc_idx) || (nested && win_idx == svc_idx));
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic                 bus_sel,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] req_in,
  output logic                 int_out,
  input  logic                 int_ack,
  output logic [DATA_W-1:0]    cfg_cascade
);
  logic                 restart, eoi_cmd, ready, level_mode, auto_eoi, nested;
  logic [DATA_W-1:0]    vbase;
  logic [NUM_LINES-1:0] mask, irr, isr, win_hot, ack_clr;
  logic [IDX_W-1:0]     win_idx;
  logic                 int_req, ack_take;

  pic_init_seq #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd(bus_wr && !bus_sel), .wr_dat(bus_wr && bus_sel), .wdata(bus_wdata),
    .restart(restart), .eoi_cmd(eoi_cmd), .ready(ready),
    .vbase(vbase), .cascade(cfg_cascade), .level_mode(level_mode),
    .auto_eoi(auto_eoi), .nested(nested), .mask(mask)
  );

  assign ack_take = int_ack && int_req;
  assign ack_clr  = ack_take ? win_hot : '0;

  pic_req_latch #(.NUM_LINES(NUM_LINES)) u_req (
    .clk(clk), .rst_n(rst_n), .clear_all(restart), .level_mode(level_mode),
    .req_in(req_in), .ack_clr(ack_clr), .irr(irr)
  );

  pic_prio_resolve #(.NUM_LINES(NUM_LINES)) u_prio (
    .ready(ready), .nested(nested), .irr(irr), .mask(mask), .isr(isr),
    .int_req(int_req), .win_idx(win_idx), .win_hot(win_hot)
  );

  // in-service register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= '0;
    end else if (restart) begin
      isr <= '0;
    end else begin
      isr <= (eoi_cmd ? (isr & (isr - 1'b1)) : isr) |
             ((ack_take && !auto_eoi) ? win_hot : '0);
    end
  end

  always_comb begin
    if (int_ack)
      bus_rdata = vbase + DATA_W'(int_req ? win_idx : IDX_W'(NUM_LINES - 1));
    else if (bus_rd && bus_sel)
      bus_rdata = DATA_W'(mask) | ~DATA_W'({NUM_LINES{1'b1}}) & {DATA_W{!ready}};
    else
      bus_rdata = '0;
  end

  assign int_out = int_req;
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int NUM_LINES = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 int_out,
  input logic                 int_ack,
  input logic                 ready,
  input logic                 restart,
  input logic                 eoi_cmd,
  input logic                 auto_eoi,
  input logic                 nested,
  input logic [NUM_LINES-1:0] irr,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] isr
);
  a_r1_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  a_r5_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  a_r7_ack_adds_service: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !auto_eoi && !nested && !eoi_cmd && !restart)
      |=> ($countones(isr) == $countones($past(isr)) + 1));

  a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !int_ack && (isr != '0))
      |=> ($countones(isr) == $countones($past(isr)) - 1));

  a_r9_auto_no_service: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_eoi && int_ack && !eoi_cmd && !restart) |=> $stable(isr));

  a_r14_spurious_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_out && !eoi_cmd && !restart) |=> $stable(isr));
endmodule

bind pic_ctrl pic_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .int_ack(int_ack),
  .ready(ready), .restart(restart), .eoi_cmd(eoi_cmd), .auto_eoi(auto_eoi),
  .nested(nested), .irr(irr), .mask(mask), .isr(isr)
);

// File: tb/pic_ctrl_tb_top.sv
module pic_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0, int_ack = 1'b0;
  logic [7:0] bus_wdata = 8'h00, req_in = 8'h00;
  logic [7:0] bus_rdata, cfg_cascade;
  logic       int_out;
  int         n_checks = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in),
    .int_out(int_out), .int_ack(int_ack), .cfg_cascade(cfg_cascade)
  );

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd_mask(output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_sel = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk);
    int_ack = 1'b1;
    #1 v = bus_rdata;
    @(posedge clk);
    #1 int_ack = 1'b0;
  endtask

  // drive request lines, then sample int_out one falling edge later
  task automatic set_req(logic [7:0] v, output logic io);
    @(negedge clk);
    req_in = v;
    @(negedge clk);
    #1 io = int_out;
  endtask

  task automatic int_now(output logic io);
    @(negedge clk);
    #1 io = int_out;
  endtask

  task automatic t_reset;
    logic [7:0] v; logic io;
    check("R1 int after reset", {7'd0, int_out}, 8'h00);
    rd_mask(v);  check("R1 mask read before init", v, 8'hFF);
    wr(1'b1, 8'h12);
    rd_mask(v);  check("R1 data write ignored before init", v, 8'hFF);
    set_req(8'h01, io); check("R1 no int before init", {7'd0, io}, 8'h00);
    req_in = 8'h00;
  endtask

  task automatic t_cascade_init;
    logic [7:0] v;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    check("R2 cascade word stored", cfg_cascade, 8'h04);
    rd_mask(v); check("R4 mask cleared after init", v, 8'h00);
  endtask

  task automatic t_edge_priority;
    logic [7:0] v; logic io;
    set_req(8'h28, io); check("R10 edge latched raises int", {7'd0, io}, 8'h01);
    ack(v); check("R6 vector of line 3", v, 8'h23);
    int_now(io); check("R7 lower line blocked", {7'd0, io}, 8'h00);
    set_req(8'h00, io); check("R10 latch held after input falls", {7'd0, io}, 8'h00);
    set_req(8'h02, io); check("R7 higher line preempts", {7'd0, io}, 8'h01);
    ack(v); check("R6 vector of line 1", v, 8'h21);
    req_in = 8'h00;
    wr(1'b0, 8'h20); int_now(io); check("R8 eoi frees line 1 only", {7'd0, io}, 8'h00);
    wr(1'b0, 8'h0B); int_now(io); check("R8 other command ignored", {7'd0, io}, 8'h00);
    wr(1'b0, 8'h20); int_now(io); check("R8 eoi frees line 3", {7'd0, io}, 8'h01);
    ack(v); check("R10 line 5 kept latched", v, 8'h25);
    wr(1'b0, 8'h20);
    set_req(8'h01, io); ack(v); check("R6 vector of line 0", v, 8'h20);
    wr(1'b0, 8'h20); int_now(io); check("R10 held input not relatched", {7'd0, io}, 8'h00);
    set_req(8'h00, io);
    set_req(8'h01, io); check("R10 new rising edge latched", {7'd0, io}, 8'h01);
    ack(v); wr(1'b0, 8'h20); req_in = 8'h00;
  endtask

  task automatic t_mask;
    logic [7:0] v; logic io;
    wr(1'b1, 8'h04);
    rd_mask(v); check("R5 mask readback", v, 8'h04);
    set_req(8'h04, io); check("R5 masked line silent", {7'd0, io}, 8'h00);
    wr(1'b1, 8'h00); int_now(io); check("R5 unmask releases kept request", {7'd0, io}, 8'h01);
    ack(v); check("R5 vector after unmask", v, 8'h22);
    wr(1'b0, 8'h20); req_in = 8'h00;
  endtask

  task automatic t_spurious;
    logic [7:0] v; logic io;
    int_now(io); check("R14 idle before ack", {7'd0, io}, 8'h00);
    ack(v); check("R14 spurious vector", v, 8'h27);
    set_req(8'h80, io); check("R14 no service recorded", {7'd0, io}, 8'h01);
    ack(v); wr(1'b0, 8'h20); req_in = 8'h00;
  endtask

  task automatic t_restart_level;
    logic [7:0] v; logic io;
    wr(1'b0, 8'h11); wr(1'b1, 8'h40);
    wr(1'b0, 8'h1A); wr(1'b1, 8'h60);
    rd_mask(v); check("R13 restart without mode word completes", v, 8'h00);
    wr(1'b1, 8'h80);
    rd_mask(v); check("R3 single mode skips cascade word", v, 8'h80);
    wr(1'b1, 8'h00);
    @(negedge clk); req_in = 8'h04; #1;
    check("R11 level follows input same cycle", {7'd0, int_out}, 8'h01);
    @(negedge clk); req_in = 8'h00; #1;
    check("R11 level drops with input", {7'd0, int_out}, 8'h00);
    @(negedge clk); req_in = 8'h04;
    ack(v); check("R6 level vector", v, 8'h62);
    int_now(io); check("R7 equal line blocked while in service", {7'd0, io}, 8'h00);
    wr(1'b0, 8'h20); int_now(io); check("R11 level request returns after eoi", {7'd0, io}, 8'h01);
    req_in = 8'h00;
  endtask

  task automatic t_auto_nested;
    logic [7:0] v; logic io;
    wr(1'b0, 8'h13); wr(1'b1, 8'h80); wr(1'b1, 8'h02);
    set_req(8'h08, io); ack(v); check("R9 vector auto eoi", v, 8'h83);
    set_req(8'h28, io); check("R9 lower line raises at once", {7'd0, io}, 8'h01);
    ack(v); check("R9 lower vector", v, 8'h85);
    req_in = 8'h00;
    wr(1'b0, 8'h13); wr(1'b1, 8'h80); wr(1'b1, 8'h10);
    set_req(8'h08, io); ack(v);
    set_req(8'h00, io);
    set_req(8'h08, io); check("R12 same line nests", {7'd0, io}, 8'h01);
    ack(v); wr(1'b0, 8'h20); req_in = 8'h00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cascade_init();
    t_edge_priority();
    t_mask();
    t_spurious();
    t_restart_level();
    t_auto_nested();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule